// File: doc/BRIEF.md
# Byte Bit-Manipulation Execution Unit

This unit carries out single-bit operations on a byte operand inside a small microcontroller datapath. For each operation the surrounding pipeline supplies an opcode, the byte to work on, a bit number and the current Z and C flags. The bit number comes either from a 3-bit immediate field or from the low bits of a general register. The unit then does one of three things. It writes back a modified byte, it reports a new Z flag, or it reports a new C flag. It can also flag the operation as illegal.

There are two groups of operations. The first group sets, clears or inverts one bit and writes the byte back, or tests one bit into Z. The second group combines the carry flag with the selected bit, or with its complement, and changes only C. Both flags pass straight through whenever an operation does not target them.

A valid/ready handshake feeds one register stage. While a result is pending the unit refuses new work, so the read-modify-write of a memory operand cannot overlap the operation that follows it.

Top module: `bitop_unit`

## Requirements
- R1: Opcode 4'h0 (set) returns the operand with the selected bit forced to 1 and every other bit unchanged, and asserts the byte write-enable.
- R2: Opcode 4'h1 (clear) returns the operand with the selected bit forced to 0 and every other bit unchanged, and asserts the byte write-enable.
- R3: Opcode 4'h2 (invert) returns the operand with the selected bit complemented and every other bit unchanged, and asserts the byte write-enable.
- R4: Opcode 4'h3 (test) returns Z equal to the complement of the selected bit and asserts only the Z strobe. The returned byte equals the operand.
- R5: When the source-select input is 1, the bit number is taken from bits [2:0] of the register input, and the higher register bits have no effect and raise no error. When it is 0, the bit number is the 3-bit immediate.
- R6: Opcode 4'h4 gives C = C AND bit. Opcode 4'h5 gives C = C AND NOT bit. Only the C strobe is asserted.
- R7: Opcode 4'h6 gives C = C OR bit. Opcode 4'h7 gives C = C OR NOT bit. Only the C strobe is asserted.
- R8: Opcode 4'h8 gives C = C XOR bit with only the C strobe asserted. At most one of write-enable, Z strobe, C strobe and illegal is ever high.
- R9: Opcodes 4'h4 to 4'h8 with the register source selected assert illegal. They assert no write-enable and no flag strobe.
- R10: Opcodes 4'h9 to 4'hF assert illegal for one cycle. They assert no write-enable and no flag strobe.
- R11: The result and its strobes appear, with out_valid high, in the cycle after the handshake is accepted, and they last for exactly one cycle. in_ready is low during that cycle.
- R12: After reset, out_valid and all strobes are 0 and in_ready is 1. A flag output that the operation does not target equals the flag input that was presented with that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 4 | Opcode |
| in_use_reg | input | 1 | 1: bit number from register, 0: from immediate |
| in_imm | input | IDX_W (3) | Immediate bit number |
| in_reg | input | REG_W (16) | General register value supplying the bit number |
| in_data | input | DATA_W (8) | Operand byte |
| in_z | input | 1 | Current Z flag |
| in_c | input | 1 | Current C flag |
| out_valid | output | 1 | Result valid for one cycle |
| out_data | output | DATA_W (8) | Resulting byte |
| out_we | output | 1 | Byte write-enable |
| out_z_we | output | 1 | Z update strobe |
| out_z | output | 1 | Z flag result |
| out_c_we | output | 1 | C update strobe |
| out_c | output | 1 | C flag result |
| out_illegal | output | 1 | Illegal operation, one cycle |

## Verification
The bench builds the unit with DATA_W=8 and REG_W=16. The wider register lets it place random patterns in register bits 15:3, so the test of whether upper bits are ignored covers more than a single stray bit. Every one of the sixteen opcode values runs at all eight bit positions, with both bit-number sources, both carry values and several operand patterns. The set then reaches every legal operation, every rejected register-sourced carry operation and every undefined code.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam logic [3:0] OP_SET   = 4'h0;
  localparam logic [3:0] OP_CLR   = 4'h1;
  localparam logic [3:0] OP_INV   = 4'h2;
  localparam logic [3:0] OP_TST   = 4'h3;
  localparam logic [3:0] OP_CAND  = 4'h4;
  localparam logic [3:0] OP_CANDN = 4'h5;
  localparam logic [3:0] OP_COR   = 4'h6;
  localparam logic [3:0] OP_CORN  = 4'h7;
  localparam logic [3:0] OP_CXOR  = 4'h8;

  typedef struct packed {
    logic we;
    logic z_we;
    logic z;
    logic c_we;
    logic c;
    logic illegal;
  } bitop_flags_t;

  function automatic logic is_carry_op(input logic [3:0] op);
    return (op >= OP_CAND) && (op <= OP_CXOR);
  endfunction

  function automatic logic is_write_op(input logic [3:0] op);
    return (op == OP_SET) || (op == OP_CLR) || (op == OP_INV);
  endfunction

  // New carry from current carry and the selected bit.
  function automatic logic carry_logic(input logic [3:0] op, input logic c, input logic b);
    case (op)
      OP_CAND:  return c & b;
      OP_CANDN: return c & ~b;
      OP_COR:   return c | b;
      OP_CORN:  return c | ~b;
      OP_CXOR:  return c ^ b;
      default:  return c;
    endcase
  endfunction

endpackage

// File: rtl/bitop_index.sv
module bitop_index #(
  parameter int IDX_W = 3,
  parameter int REG_W = 16
) (
  input  logic             use_reg,
  input  logic [IDX_W-1:0] imm,
  input  logic [REG_W-1:0] regval,
  output logic [IDX_W-1:0] idx
);
  // Only the low index bits of the register take part.
  always_comb idx = use_reg ? regval[IDX_W-1:0] : imm;
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [3:0]        op,
  input  logic              use_reg,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] data,
  input  logic              z_in,
  input  logic              c_in,
  output logic [DATA_W-1:0] data_res,
  output bitop_flags_t      flags
);
  logic [DATA_W-1:0] mask;
  logic              sel_bit;
  logic              carry_rejected;
  logic              undefined_op;

  always_comb begin
    mask           = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
    sel_bit        = data[idx];
    carry_rejected = is_carry_op(op) && use_reg;
    undefined_op   = !is_carry_op(op) && !is_write_op(op) && (op != OP_TST);
  end

  always_comb begin
    data_res      = data;
    flags         = '0;
    flags.z       = z_in;
    flags.c       = c_in;
    if (undefined_op || carry_rejected) begin
      flags.illegal = 1'b1;
    end else begin
      case (op)
        OP_SET: begin data_res = data | mask;  flags.we = 1'b1; end
        OP_CLR: begin data_res = data & ~mask; flags.we = 1'b1; end
        OP_INV: begin data_res = data ^ mask;  flags.we = 1'b1; end
        OP_TST: begin flags.z = ~sel_bit;      flags.z_we = 1'b1; end
        default: begin
          flags.c    = carry_logic(op, c_in, sel_bit);
          flags.c_we = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 16,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic              in_use_reg,
  input  logic [IDX_W-1:0]  in_imm,
  input  logic [REG_W-1:0]  in_reg,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_z,
  input  logic              in_c,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_we,
  output logic              out_z_we,
  output logic              out_z,
  output logic              out_c_we,
  output logic              out_c,
  output logic              out_illegal
);
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] alu_data;
  bitop_flags_t      alu_flags;
  bitop_flags_t      res_flags;
  logic              accept;

  bitop_index #(.IDX_W(IDX_W), .REG_W(REG_W)) u_index (
    .use_reg(in_use_reg), .imm(in_imm), .regval(in_reg), .idx(bit_idx)
  );

  bitop_alu #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_alu (
    .op(in_op), .use_reg(in_use_reg), .idx(bit_idx), .data(in_data),
    .z_in(in_z), .c_in(in_c), .data_res(alu_data), .flags(alu_flags)
  );

  // A pending result blocks the next operation.
  assign in_ready = !out_valid;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      res_flags <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_data  <= alu_data;
        res_flags <= alu_flags;
      end else begin
        res_flags.we      <= 1'b0;
        res_flags.z_we    <= 1'b0;
        res_flags.c_we    <= 1'b0;
        res_flags.illegal <= 1'b0;
      end
    end
  end

  assign out_we      = res_flags.we;
  assign out_z_we    = res_flags.z_we;
  assign out_z       = res_flags.z;
  assign out_c_we    = res_flags.c_we;
  assign out_c       = res_flags.c;
  assign out_illegal = res_flags.illegal;

  // R11
  result_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_we, out_z_we, out_c_we, out_illegal}));

  // R10
  strobe_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we || out_z_we || out_c_we || out_illegal) |-> out_valid);

  // R1
  write_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> ($countones(out_data ^ $past(in_data)) <= 1));

  // R4
  test_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_z_we |-> (out_data == $past(in_data)));

  // R12
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_c_we) |-> (out_c == $past(in_c)));
endmodule

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;
  localparam int DATA_W = 8;
  localparam int REG_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [3:0]        in_op = '0;
  logic              in_use_reg = 1'b0;
  logic [2:0]        in_imm = '0;
  logic [REG_W-1:0]  in_reg = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_z = 1'b0;
  logic              in_c = 1'b0;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;
  logic              out_we, out_z_we, out_z, out_c_we, out_c, out_illegal;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  bitop_unit #(.DATA_W(DATA_W), .REG_W(REG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_use_reg(in_use_reg), .in_imm(in_imm), .in_reg(in_reg),
    .in_data(in_data), .in_z(in_z), .in_c(in_c), .out_valid(out_valid),
    .out_data(out_data), .out_we(out_we), .out_z_we(out_z_we), .out_z(out_z),
    .out_c_we(out_c_we), .out_c(out_c), .out_illegal(out_illegal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int op, input bit use_reg, input bit upper_set);
    if (op > 8) return "R10";
    if (op >= 4 && use_reg) return "R9";
    if (use_reg && upper_set) return "R5";
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5: return "R6";
      6, 7: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Sends one operation and checks the whole result bundle against the model.
  task automatic run_op(input int op, input bit use_reg, input int bitn,
                        input logic [7:0] d, input bit z, input bit c, input logic [15:0] hi);
    logic [7:0] e_d;
    logic e_we, e_zwe, e_z, e_cwe, e_c, e_ill, b;
    string tag;
    @(negedge clk);
    in_valid = 1'b1; in_op = op[3:0]; in_use_reg = use_reg; in_data = d;
    in_z = z; in_c = c;
    if (use_reg) begin in_imm = 3'(~bitn); in_reg = {hi[15:3], 3'(bitn)}; end
    else begin in_imm = 3'(bitn); in_reg = {hi[15:3], 3'(~bitn)}; end
    b = d[bitn];
    e_d = d; e_we = 0; e_zwe = 0; e_z = z; e_cwe = 0; e_c = c; e_ill = 0;
    if (op > 8 || (op >= 4 && use_reg)) e_ill = 1;
    else case (op)
      0: begin e_d[bitn] = 1'b1; e_we = 1; end
      1: begin e_d[bitn] = 1'b0; e_we = 1; end
      2: begin e_d[bitn] = !b;   e_we = 1; end
      3: begin e_z = !b; e_zwe = 1; end
      4: begin e_c = c && b;   e_cwe = 1; end
      5: begin e_c = c && !b;  e_cwe = 1; end
      6: begin e_c = c || b;   e_cwe = 1; end
      7: begin e_c = c || !b;  e_cwe = 1; end
      default: begin e_c = c != b; e_cwe = 1; end
    endcase
    tag = tag_of(op, use_reg, hi[15:3] != 0);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " result"},
          {14'd0, out_valid, in_ready, e_d, out_we, out_z_we, out_z, out_c_we, out_c, out_illegal, 2'd0},
          {14'd0, 1'b1, 1'b0, e_d, e_we, e_zwe, e_z, e_cwe, e_c, e_ill, 2'd0} | {16'd0, out_data ^ e_d, 8'd0});
    check({tag, " data"}, {24'd0, out_data}, {24'd0, e_d});
    @(negedge clk);
    check("R11 pulse", {29'd0, out_valid, in_ready, out_illegal}, {29'd0, 1'b0, 1'b1, 1'b0});
  endtask

  task automatic t_reset;
    check("R12 reset", {26'd0, out_valid, in_ready, out_we, out_z_we, out_c_we, out_illegal},
          {26'd0, 1'b0, 1'b1, 4'b0000});
  endtask

  task automatic t_sweep;
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    for (int op = 0; op < 16; op++)
      for (int bn = 0; bn < 8; bn++)
        for (int p = 0; p < 4; p++)
          for (int src = 0; src < 2; src++)
            run_op(op, src[0], bn, pats[p], p[0], p[1] ^ bn[0], 16'($urandom));
  endtask

  // R11: a held valid is taken only every other cycle.
  task automatic t_backpressure;
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'h0; in_use_reg = 0; in_imm = 3'd2; in_data = 8'h00;
    @(negedge clk);
    check("R11 busy", {30'd0, out_valid, in_ready}, {30'd0, 1'b1, 1'b0});
    in_imm = 3'd5;
    @(negedge clk);
    check("R11 idle", {30'd0, out_valid, in_ready}, {30'd0, 1'b0, 1'b1});
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 second", {23'd0, out_valid, out_data}, {23'd0, 1'b1, 8'h20});
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sweep();
        t_backpressure();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule